// File: doc/BRIEF.md
# Per-Space Wait-State Generator

This block stretches external bus accesses by a programmable number of clock cycles. An access can target one of four off-chip address spaces: lower program, upper program, data or I/O. A 12-bit configuration word holds one 3-bit wait count for each space and is loaded through a simple write port. When the bus master strobes the start of an access, the generator takes the count for the selected space and holds `bus_ready` low for that many cycles. After that it passes the external `ext_ready` line through, so a slow device can add further cycles one at a time.

The sequencer has three named states. In `WS_IDLE`, `bus_ready` is high and a start strobe is accepted. That transition goes to `WS_COUNT` when the sampled count is non-zero and straight to `WS_HANDOFF` when the count is zero. In `WS_COUNT`, `bus_ready` is low and the counter steps down by one each cycle. When the counter is at 1, the next transition goes to `WS_HANDOFF`. In `WS_HANDOFF`, `bus_ready` follows `ext_ready`, and the transition back to `WS_IDLE` happens on the first cycle in which `ext_ready` is high.

Top module: `wsg_top`

## Requirements
- R1: A synchronous reset sets every configuration bit to 1, so `cfg_rdata` reads 0xFFF and each of the four spaces inserts seven wait states.
- R2: The wait count for an access is taken from the field picked by `space_sel`: code 0 (lower program) uses bits 2:0, code 1 (upper program) uses bits 5:3, code 2 (data) uses bits 8:6, and code 3 (I/O) uses bits 11:9.
- R3: Each field is an unsigned binary count from 0 to 7. With `ext_ready` held high, an access with count w keeps `bus_ready` low for exactly w cycles, starting in the cycle after the start strobe.
- R4: A cycle with `wr_en` high loads all 12 bits of `wr_data`, and the new value appears on `cfg_rdata` in the next cycle. For example, writing 0x03F after 0x000 gives seven wait states on both program spaces and zero on data and I/O.
- R5: The count is sampled in the start cycle. A write in that same cycle, or in any later cycle of the access, changes only later accesses.
- R6: After the programmed wait states, every cycle in which `ext_ready` is low adds one more low cycle of `bus_ready`. A low `ext_ready` while the programmed count is still running adds nothing.
- R7: An access with count w and k cycles of `ext_ready` low after the count completes in w + k added cycles. With a count of 0 and `ext_ready` high, `bus_ready` never drops.
- R8: While idle, `bus_ready` is high. A start strobe that arrives while an access is in progress is ignored, so it neither restarts nor extends that access and starts no new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| access_start | input | 1 | One-cycle strobe marking the start of an external access |
| space_sel | input | 2 | Target space: 0 lower program, 1 upper program, 2 data, 3 I/O |
| ext_ready | input | 1 | External ready; low stretches the access once the count has run out |
| wr_en | input | 1 | Configuration write enable |
| wr_data | input | 12 | Configuration write value |
| bus_ready | output | 1 | High when the bus master may complete or start a cycle |
| cfg_rdata | output | 12 | Current configuration value |

## Verification
The first wait cycle of an access falls in the clock after its start strobe. `bus_ready` is registered state combined with `ext_ready` in the same cycle, so its value for a cycle is known once that cycle's inputs are applied. A configuration write shows on `cfg_rdata` one edge later, and only an access started after that edge uses the new value. The bench drives inputs just after each rising edge and samples shortly after the falling edge. It compares `bus_ready` and `cfg_rdata` with its behavioural model in every cycle. It also counts the low cycles of each access and checks that total against the programmed count plus the number of stretch cycles.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

    // Sequencer states of the wait-state generator.
    typedef enum logic [1:0] {
        WS_IDLE    = 2'd0,
        WS_COUNT   = 2'd1,
        WS_HANDOFF = 2'd2
    } wsg_state_e;

endpackage

// File: rtl/wsg_cfg_reg.sv
module wsg_cfg_reg #(
    parameter int CFG_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en_i,
    input  logic [CFG_W-1:0] wr_data_i,
    output logic [CFG_W-1:0] cfg_o
);

    logic [CFG_W-1:0] cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '1;
        end else if (wr_en_i) begin
            cfg_q <= wr_data_i;
        end
    end

    assign cfg_o = cfg_q;

    // R4
    write_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> (cfg_o == $past(wr_data_i)));

endmodule

// File: rtl/wsg_field_sel.sv
module wsg_field_sel #(
    parameter int CNT_W      = 3,
    parameter int NUM_SPACES = 4,
    localparam int SEL_W     = (NUM_SPACES > 1) ? $clog2(NUM_SPACES) : 1,
    localparam int CFG_W     = CNT_W * NUM_SPACES
) (
    input  logic [CFG_W-1:0] cfg_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [CNT_W-1:0] wait_o
);

    logic [CNT_W-1:0] field [NUM_SPACES];

    // Field g of the word sits at bits [g*CNT_W +: CNT_W].
    for (genvar g = 0; g < NUM_SPACES; g++) begin : g_unpack
        assign field[g] = cfg_i[g*CNT_W +: CNT_W];
    end

    assign wait_o = field[sel_i];

endmodule

// File: rtl/wsg_fsm.sv
module wsg_fsm
    import wsg_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CNT_W-1:0] wait_i,
    input  logic             ext_ready_i,
    output logic             ready_o
);

    wsg_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Remaining programmed wait count
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            WS_IDLE: begin
                if (start_i) begin
                    cnt_d   = wait_i;
                    state_d = (wait_i == '0) ? WS_HANDOFF : WS_COUNT;
                end
            end
            WS_COUNT: begin
                cnt_d = cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    state_d = WS_HANDOFF;
                end
            end
            WS_HANDOFF: begin
                if (ext_ready_i) begin
                    state_d = WS_IDLE;
                end
            end
            default: state_d = WS_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            WS_IDLE:    ready_o = 1'b1;
            WS_COUNT:   ready_o = 1'b0;
            WS_HANDOFF: ready_o = ext_ready_i;
            default:    ready_o = 1'b1;
        endcase
    end

    // R5
    load_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == WS_IDLE && start_i && wait_i != '0)
        |=> (state_q == WS_COUNT && cnt_q == $past(wait_i)));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == WS_COUNT && cnt_q > CNT_W'(1))
        |=> (state_q == WS_COUNT && cnt_q == $past(cnt_q) - 1'b1));

    // R3
    count_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == WS_COUNT) |-> (cnt_q != '0));

    // R6
    stretch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == WS_HANDOFF && !ext_ready_i) |=> (state_q == WS_HANDOFF));

endmodule

// File: rtl/wsg_top.sv
module wsg_top #(
    parameter int CNT_W      = 3,
    parameter int NUM_SPACES = 4,
    localparam int SEL_W     = (NUM_SPACES > 1) ? $clog2(NUM_SPACES) : 1,
    localparam int CFG_W     = CNT_W * NUM_SPACES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             access_start,
    input  logic [SEL_W-1:0] space_sel,
    input  logic             ext_ready,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic             bus_ready,
    output logic [CFG_W-1:0] cfg_rdata
);

    logic [CFG_W-1:0] cfg;
    logic [CNT_W-1:0] sel_wait;

    wsg_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en_i  (wr_en),
        .wr_data_i(wr_data),
        .cfg_o    (cfg)
    );

    wsg_field_sel #(.CNT_W(CNT_W), .NUM_SPACES(NUM_SPACES)) u_sel (
        .cfg_i (cfg),
        .sel_i (space_sel),
        .wait_o(sel_wait)
    );

    wsg_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start_i    (access_start),
        .wait_i     (sel_wait),
        .ext_ready_i(ext_ready),
        .ready_o    (bus_ready)
    );

    assign cfg_rdata = cfg;

endmodule

// File: tb/tb_wsg_top.sv
`timescale 1ns/1ps
module tb_wsg_top;

    localparam real HALF = 4.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        access_start = 1'b0;
    logic [1:0]  space_sel = 2'd0;
    logic        ext_ready = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] wr_data = '0;
    logic        bus_ready;
    logic [11:0] cfg_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural reference state
    bit          m_busy = 0;
    int          m_left = 0;
    logic [11:0] m_cfg  = 12'hFFF;

    always #(HALF) clk = ~clk;

    wsg_top dut (
        .clk(clk), .rst(rst), .access_start(access_start), .space_sel(space_sel),
        .ext_ready(ext_ready), .wr_en(wr_en), .wr_data(wr_data),
        .bus_ready(bus_ready), .cfg_rdata(cfg_rdata)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock: compare after the falling edge, then advance the model.
    task automatic step(output bit rdy);
        bit exp_rdy;
        @(negedge clk);
        #1;
        exp_rdy = !m_busy ? 1'b1 : ((m_left > 0) ? 1'b0 : ext_ready);
        rdy = bus_ready;
        if (!rst) begin
            chk(bus_ready === exp_rdy, "R7 per-cycle bus_ready", int'(bus_ready), int'(exp_rdy));
            chk(cfg_rdata === m_cfg, "R4 per-cycle readback", int'(cfg_rdata), int'(m_cfg));
        end
        @(posedge clk);
        if (rst) begin
            m_cfg  = 12'hFFF;
            m_busy = 0;
            m_left = 0;
        end else begin
            if (!m_busy) begin
                if (access_start) begin
                    m_busy = 1;
                    m_left = int'((m_cfg >> (3 * int'(space_sel))) & 12'h7);
                end
            end else if (m_left > 0) begin
                m_left--;
            end else if (ext_ready) begin
                m_busy = 0;
            end
            if (wr_en) m_cfg = wr_data;
        end
        #1;
        access_start = 1'b0;
        wr_en        = 1'b0;
    endtask

    // Cycles after the start strobe until bus_ready is high again.
    task automatic run_out(input int hold_low, output int low);
        bit r;
        low = 0;
        for (int i = 0; i < 64; i++) begin
            ext_ready = (i < hold_low) ? 1'b0 : 1'b1;
            step(r);
            if (r) break;
            low++;
        end
        ext_ready = 1'b1;
    endtask

    task automatic access(input int sp, input int w, input int k, input string tag);
        bit r;
        int low;
        space_sel    = 2'(sp);
        access_start = 1'b1;
        ext_ready    = 1'b1;
        step(r);
        run_out(w + k, low);
        chk(low == w + k, tag, low, w + k);
    endtask

    task automatic write_cfg(input logic [11:0] v);
        bit r;
        wr_en   = 1'b1;
        wr_data = v;
        step(r);
    endtask

    initial begin
        #(HALF * 2.0 * 150000.0);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit r;
        int low;
        logic [11:0] pat;

        step(r);
        step(r);
        rst = 1'b0;
        step(r);
        // R1 reset value
        chk(cfg_rdata == 12'hFFF, "R1 reset readback", int'(cfg_rdata), 12'hFFF);
        // R8 idle ready
        chk(r == 1'b1, "R8 idle bus_ready", int'(r), 1);
        for (int s = 0; s < 4; s++) access(s, 7, 0, "R1 default seven waits");

        // R2/R3 every space at every field value, fields kept distinct
        for (int v = 0; v < 8; v++) begin
            pat = '0;
            for (int s = 0; s < 4; s++) pat[3*s +: 3] = 3'((v + s) % 8);
            write_cfg(pat);
            for (int s = 0; s < 4; s++) access(s, (v + s) % 8, 0, "R2 R3 field count");
        end

        // R4 writing ones to bits 5:0 only
        write_cfg(12'h000);
        write_cfg(12'h03F);
        chk(cfg_rdata == 12'h03F, "R4 readback 03F", int'(cfg_rdata), 12'h03F);
        access(0, 7, 0, "R4 lower program seven");
        access(1, 7, 0, "R4 upper program seven");
        access(2, 0, 0, "R4 data unchanged");
        access(3, 0, 0, "R4 io unchanged");

        // R6/R7 ready stretch of several lengths
        write_cfg(12'h492);  // all fields 2
        access(2, 2, 1, "R6 stretch 1");
        access(3, 2, 3, "R6 stretch 3");
        access(0, 2, 5, "R6 stretch 5");
        write_cfg(12'h000);
        access(1, 0, 4, "R6 zero count stretch 4");
        access(2, 0, 0, "R7 zero count no drop");

        // R6 ext_ready low only during the programmed count has no effect
        write_cfg(12'h004);  // lower program 4
        space_sel = 2'd0; access_start = 1'b1; step(r);
        for (int i = 0; i < 3; i++) begin ext_ready = 1'b0; step(r); end
        run_out(0, low);
        chk(low + 3 == 4, "R6 low during count ignored", low + 3, 4);

        // R5 write during an access
        write_cfg(12'h005);
        space_sel = 2'd0; access_start = 1'b1; step(r);
        step(r);
        wr_en = 1'b1; wr_data = 12'h001; step(r);
        run_out(0, low);
        chk(low + 2 == 5, "R5 write mid-access", low + 2, 5);
        access(0, 1, 0, "R5 later access uses new count");

        // R5 write in the start cycle
        space_sel = 2'd0; access_start = 1'b1; wr_en = 1'b1; wr_data = 12'h003;
        step(r);
        run_out(0, low);
        chk(low == 1, "R5 same-cycle write", low, 1);
        access(0, 3, 0, "R5 next access after same-cycle write");

        // R8 start while busy is ignored
        write_cfg(12'h005);
        space_sel = 2'd0; access_start = 1'b1; step(r);
        step(r);
        space_sel = 2'd3; access_start = 1'b1; step(r);
        run_out(0, low);
        chk(low + 2 == 5, "R8 busy start ignored length", low + 2, 5);
        step(r);
        chk(r == 1'b1, "R8 no new access started", int'(r), 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule